// File: doc/BRIEF.md
# Serial Latch Programming and Reset Sequencer

This block is the write port and control sequencer of a clock-synthesis PLL. A host writes 24-bit words over three wires: a serial clock, a data line and a load strobe. The block samples all three on its own system clock, shifts the data in most significant bit first, and when the load strobe rises it copies the word into one of three holding latches: the reference-divider latch, the feedback-divider latch, or the function latch. A fourth code, the initialization write, loads the function latch and also starts a reset of the divider counters.

From the function latch contents, a chip-enable input and a reference-divider event pulse, the block derives four outputs. The first is a single-cycle counter reset pulse. The others are a counter hold level, a charge-pump tristate level and the power-down state. An initialization write arms a one-shot, so that the next feedback-divider load repeats the reset pulse once. Power-down can take effect as soon as the latch is written. In the synchronous form it waits for the next reference-divider event, so the loop is not disturbed in the middle of a phase comparison.

Top module: `pll_ser_ctrl`

## Requirements
- R1: Each rising edge of the synchronized serial clock shifts the synchronized data bit into a 24-bit register at bit 0. After 24 edges, the first bit sent sits at bit 23.
- R2: A rising edge of the synchronized load strobe copies the whole word into one latch, selected by word bits [1:0]: 00 updates `ref_word`, 01 updates `fb_word`, and both 10 and 11 update `func_word`. The other latches are left unchanged.
- R3: A write with code 11 (initialization) produces exactly one `cnt_rst_pulse` cycle.
- R4: The first code-01 write after an initialization write produces exactly one `cnt_rst_pulse` cycle. Code-01 writes after that one, and code-01 writes with no initialization before them, produce none.
- R5: While function bit 2 is 1, `cnt_hold` and `cp_tristate` are high and `pwr_down` stays low (if chip enable is high and bit 3 is 0).
- R6: While `chip_en` is low, `pwr_down` is high no later than three system clocks later, whatever bits 3 and 21 hold.
- R7: With function bit 21 = 0 and bit 3 = 1, `pwr_down` rises within two system clocks of the function latch update.
- R8: With function bit 21 = 1 and bit 3 = 1, `pwr_down` stays low until a `ref_evt` pulse, and is high from the clock edge after that pulse.
- R9: While `pwr_down` is high, `cnt_hold` and `cp_tristate` are high, and serial words are still shifted in and latched.
- R10: After reset, all three latches read zero and `cnt_rst_pulse` is low.
- R11: Writing function bit 3 = 0 with chip enable high clears `pwr_down`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first, asynchronous |
| ser_le | input | 1 | Load strobe; rising edge latches the word |
| chip_en | input | 1 | Chip enable; low forces power-down |
| ref_evt | input | 1 | One-cycle pulse on each reference-divider output event |
| ref_word | output | 24 | Reference-divider latch contents |
| fb_word | output | 24 | Feedback-divider latch contents |
| func_word | output | 24 | Function latch contents |
| cnt_rst_pulse | output | 1 | One-cycle counter reset pulse |
| cnt_hold | output | 1 | Hold counters at load point |
| cp_tristate | output | 1 | Charge pump output disabled |
| pwr_down | output | 1 | Power-down state |

## Verification
The assertions assume that the serial inputs change slowly compared with the system clock. Each level of the serial clock and of the load strobe must last at least three system clocks, and two load strobes must be several cycles apart, so that only one strobe is in flight at a time. They also assume that `ref_evt` is a single-cycle pulse synchronous to the system clock. The stimulus holds each serial half-period for four system clocks, keeps the load strobe high for twelve cycles with at least sixteen cycles between words, and drives `ref_evt` for exactly one cycle.

// File: rtl/pll_ser_pkg.sv
// Package: shared constants and the latch-select encoding for the serial
// programming block. Assumes the word is at least 22 bits wide.
package pll_ser_pkg;
    localparam int SEL_W   = 2;
    localparam int F1_BIT  = 2;   // counter hold
    localparam int PD1_BIT = 3;   // power-down request
    localparam int PD2_BIT = 21;  // synchronous power-down select

    typedef enum logic [SEL_W-1:0] {
        SEL_REF  = 2'b00,
        SEL_FB   = 2'b01,
        SEL_FUNC = 2'b10,
        SEL_INIT = 2'b11
    } latch_sel_e;
endpackage

// File: rtl/bit_sync.sv
// Module: multi-stage synchronizer for one asynchronous level.
// Assumes STAGES >= 2; output resets to RST_VAL.
module bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ser_shift_in.sv
// Module: oversampled 3-wire receiver. It synchronizes the serial clock,
// data and load strobe, shifts on serial-clock rising edges, and emits a
// one-cycle load strobe holding the captured word.
// Assumes each serial level lasts longer than STAGES+1 system clocks.
module ser_shift_in #(
    parameter int WORD_W = 24,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic [WORD_W-1:0] word_o,
    output logic              ld_stb_o
);
    logic sclk_s, sdat_s, sle_s;
    logic sclk_d, sle_d;
    logic [WORD_W-1:0] shreg;

    bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync_clk (.clk(clk), .rst_n(rst_n), .d(ser_clk),  .q(sclk_s));
    bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync_dat (.clk(clk), .rst_n(rst_n), .d(ser_data), .q(sdat_s));
    bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync_le  (.clk(clk), .rst_n(rst_n), .d(ser_le),   .q(sle_s));

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sle_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            sle_d  <= sle_s;
        end
    end

    // Shift MSB first on each serial-clock rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                shreg <= '0;
        else if (sclk_s && !sclk_d) shreg <= {shreg[WORD_W-2:0], sdat_s};
    end

    // Capture the word and strobe once per load-strobe rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_stb_o <= 1'b0;
            word_o   <= '0;
        end else begin
            ld_stb_o <= sle_s && !sle_d;
            if (sle_s && !sle_d) word_o <= shreg;
        end
    end

    // R2: a load strobe never lasts two cycles.
    p_ld_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb_o |=> !ld_stb_o);
endmodule

// File: rtl/latch_bank.sv
// Module: decodes the control bits of a loaded word and updates the
// reference, feedback or function latch. Initialization writes load the
// function latch too. Emits registered write strobes aligned with the update.
module latch_bank
    import pll_ser_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_stb,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] ref_q,
    output logic [WORD_W-1:0] fb_q,
    output logic [WORD_W-1:0] func_q,
    output logic              fb_wr,
    output logic              init_wr
);
    latch_sel_e sel;
    logic       ref_wr, func_wr;

    assign sel = latch_sel_e'(word_i[SEL_W-1:0]);

    // Route the loaded word to its latch and flag the kind of write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= '0;
            fb_q    <= '0;
            func_q  <= '0;
            ref_wr  <= 1'b0;
            fb_wr   <= 1'b0;
            func_wr <= 1'b0;
            init_wr <= 1'b0;
        end else begin
            ref_wr  <= 1'b0;
            fb_wr   <= 1'b0;
            func_wr <= 1'b0;
            init_wr <= 1'b0;
            if (ld_stb) begin
                case (sel)
                    SEL_REF:  begin ref_q  <= word_i; ref_wr  <= 1'b1; end
                    SEL_FB:   begin fb_q   <= word_i; fb_wr   <= 1'b1; end
                    SEL_FUNC: begin func_q <= word_i; func_wr <= 1'b1; end
                    default:  begin func_q <= word_i; init_wr <= 1'b1; end
                endcase
            end
        end
    end

    // R2: at most one kind of write per cycle.
    p_one_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ref_wr, fb_wr, func_wr, init_wr}));
    // R2: a reference write leaves the feedback latch untouched.
    p_ref_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_wr |-> $stable(fb_q));
endmodule

// File: rtl/reset_seq.sv
// Module: counter reset one-shot, counter hold and power-down state.
// Assumes ref_evt is a one-cycle synchronous pulse and write strobes
// are single cycles separated by idle cycles.
module reset_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic init_wr,
    input  logic fb_wr,
    input  logic f1,
    input  logic pd1,
    input  logic pd2,
    input  logic ce_s,
    input  logic ref_evt,
    output logic rst_pulse,
    output logic cnt_hold,
    output logic cp_tristate,
    output logic pwr_down
);
    logic armed;
    logic pd_state;

    // Arm on initialization; consume on the next feedback load.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (init_wr) armed <= 1'b1;
        else if (fb_wr)   armed <= 1'b0;
    end

    // One-cycle reset pulse on initialization or the armed feedback load.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_pulse <= 1'b0;
        else        rst_pulse <= init_wr || (fb_wr && armed);
    end

    // Programmed power-down: immediate, or waiting for a reference event.
    always_ff @(posedge clk) begin
        if (!rst_n) pd_state <= 1'b0;
        else        pd_state <= pd1 && (!pd2 || pd_state || ref_evt);
    end

    assign pwr_down    = !ce_s || pd_state;
    assign cnt_hold    = f1 || pwr_down;
    assign cp_tristate = cnt_hold || rst_pulse;

    // R3: the reset pulse is one cycle wide.
    p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);
    // R4: an unarmed feedback load gives no pulse.
    p_unarmed_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_wr && !armed && !init_wr) |=> !rst_pulse);
    // R7: asynchronous request takes effect on the next edge.
    p_async_pd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pd1 && !pd2) |=> pd_state);
    // R8: synchronous request waits for a reference event.
    p_sync_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_state && pd2 && !ref_evt) |=> !pd_state);
    // R11: clearing the request releases power-down state.
    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pd1 |=> !pd_state);
endmodule

// File: rtl/pll_ser_ctrl.sv
// Module: top of the serial latch programming and reset sequencer.
// Assumes slow asynchronous serial inputs and a synchronous ref_evt pulse.
module pll_ser_ctrl
    import pll_ser_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    input  logic              chip_en,
    input  logic              ref_evt,
    output logic [WORD_W-1:0] ref_word,
    output logic [WORD_W-1:0] fb_word,
    output logic [WORD_W-1:0] func_word,
    output logic              cnt_rst_pulse,
    output logic              cnt_hold,
    output logic              cp_tristate,
    output logic              pwr_down
);
    logic [WORD_W-1:0] ld_word;
    logic              ld_stb, fb_wr, init_wr, ce_s;

    ser_shift_in #(.WORD_W(WORD_W), .STAGES(STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .word_o(ld_word), .ld_stb_o(ld_stb));

    latch_bank #(.WORD_W(WORD_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .word_i(ld_word),
        .ref_q(ref_word), .fb_q(fb_word), .func_q(func_word),
        .fb_wr(fb_wr), .init_wr(init_wr));

    bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync_ce (
        .clk(clk), .rst_n(rst_n), .d(chip_en), .q(ce_s));

    reset_seq u_seq (
        .clk(clk), .rst_n(rst_n), .init_wr(init_wr), .fb_wr(fb_wr),
        .f1(func_word[F1_BIT]), .pd1(func_word[PD1_BIT]), .pd2(func_word[PD2_BIT]),
        .ce_s(ce_s), .ref_evt(ref_evt), .rst_pulse(cnt_rst_pulse),
        .cnt_hold(cnt_hold), .cp_tristate(cp_tristate), .pwr_down(pwr_down));

    // R6: chip enable held low forces power-down.
    p_ce_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en && $past(!chip_en) && $past(!chip_en, 2)) |-> pwr_down);
    // R5: the hold bit holds counters and disables the pump.
    p_hold_f1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        func_word[F1_BIT] |-> (cnt_hold && cp_tristate));
    // R9: power-down always holds counters and disables the pump.
    p_pd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (cnt_hold && cp_tristate));
endmodule

// File: tb/tb_pll_ser_ctrl.sv
module tb_pll_ser_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SER   = 4;
    localparam int WIN        = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic chip_en = 1'b1, ref_evt = 1'b0;
    logic [23:0] ref_word, fb_word, func_word;
    logic cnt_rst_pulse, cnt_hold, cp_tristate, pwr_down;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    logic [23:0] exp_w[$];
    int          exp_p[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_ser_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .chip_en(chip_en), .ref_evt(ref_evt),
        .ref_word(ref_word), .fb_word(fb_word), .func_word(func_word),
        .cnt_rst_pulse(cnt_rst_pulse), .cnt_hold(cnt_hold),
        .cp_tristate(cp_tristate), .pwr_down(pwr_down));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: shift a word MSB first, raise the strobe, queue the expectation.
    task automatic send(input logic [23:0] w, input int pulses);
        for (int i = 23; i >= 0; i--) begin
            @(negedge clk);
            ser_data = w[i];
            repeat (HALF_SER) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HALF_SER) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (HALF_SER) @(negedge clk);
        ser_le = 1'b1;
        exp_w.push_back(w);
        exp_p.push_back(pulses);
        repeat (12) @(negedge clk);
        ser_le = 1'b0;
        repeat (HALF_SER) @(negedge clk);
    endtask

    // Monitor: pop an expectation, count pulses over a window, compare latch.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_w.size() > 0) begin
                logic [23:0] w, got;
                int p, seen;
                w = exp_w.pop_front();
                p = exp_p.pop_front();
                seen = 0;
                for (int k = 0; k < WIN; k++) begin
                    @(negedge clk);
                    if (cnt_rst_pulse) seen++;
                end
                case (w[1:0])
                    2'b00:   got = ref_word;
                    2'b01:   got = fb_word;
                    default: got = func_word;
                endcase
                chk(got == w, "R1/R2 latch word", {8'h0, got}, {8'h0, w});
                chk(seen == p, "R3/R4 reset pulse count", seen, p);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(ref_word == 0 && fb_word == 0 && func_word == 0, "R10 latches zero",
            {8'h0, ref_word | fb_word | func_word}, 0);
        chk(cnt_rst_pulse == 0, "R10 no pulse", cnt_rst_pulse, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(pwr_down == 0, "R11 powered up after reset", pwr_down, 0);

        send(24'h5A3CC4, 0);                  // R1 R2 reference latch
        chk(fb_word == 0, "R2 feedback latch untouched", {8'h0, fb_word}, 0);
        send(24'h123455, 0);                  // R4 no prior initialization
        send(24'h0F0F02, 0);                  // R2 function latch
        send(24'h00A003, 1);                  // R3 initialization
        chk(func_word == 24'h00A003, "R2 init loads function", {8'h0, func_word}, 32'h00A003);
        send(24'h000101, 1);                  // R4 first feedback load after init
        send(24'h000205, 0);                  // R4 second load: none
        send(24'h3FFFFD, 0);                  // R4 third load: none

        send(24'h000006, 0);                  // R5 hold bit
        chk(cnt_hold == 1, "R5 hold high", cnt_hold, 1);
        chk(cp_tristate == 1, "R5 tristate high", cp_tristate, 1);
        chk(pwr_down == 0, "R5 no power-down", pwr_down, 0);

        send(24'h00000A, 0);                  // R7 async power-down
        chk(pwr_down == 1, "R7 async power-down", pwr_down, 1);
        chk(cnt_hold == 1 && cp_tristate == 1, "R9 hold in power-down", {cnt_hold, cp_tristate}, 2'b11);
        send(24'h000002, 0);                  // R11 release
        chk(pwr_down == 0, "R11 release", pwr_down, 0);

        send(24'h20000A, 0);                  // R8 sync power-down
        chk(pwr_down == 0, "R8 waits for event", pwr_down, 0);
        repeat (20) @(negedge clk);
        chk(pwr_down == 0, "R8 still waiting", pwr_down, 0);
        ref_evt = 1'b1;
        @(negedge clk);
        ref_evt = 1'b0;
        chk(pwr_down == 1, "R8 down after event", pwr_down, 1);
        send(24'h000002, 0);
        chk(pwr_down == 0, "R11 release after sync", pwr_down, 0);

        chip_en = 1'b0;                       // R6 chip enable low
        repeat (4) @(negedge clk);
        chk(pwr_down == 1, "R6 chip enable down", pwr_down, 1);
        send(24'h0000F0, 0);                  // R9 still loads while down
        chk(ref_word == 24'h0000F0, "R9 loads in power-down", {8'h0, ref_word}, 32'h0000F0);
        chk(cnt_hold == 1, "R9 hold with chip enable low", cnt_hold, 1);
        chip_en = 1'b1;
        repeat (4) @(negedge clk);
        chk(pwr_down == 0, "R6 chip enable up", pwr_down, 0);

        send(24'h000003, 1);                  // R3 two inits then loads
        send(24'h000003, 1);
        send(24'h000011, 1);                  // R4 armed once
        send(24'h000021, 0);
        repeat (WIN + 4) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule